// File: doc/BRIEF.md
# Programmable Eight-Input Priority Interrupt Controller

This block collects eight edge-triggered interrupt inputs and reports the most urgent one to a processor. A simple synchronous register bus reaches two ports. Address bit 0 low selects the command port and address bit 0 high selects the data port. Software first sends a start word to the command port and then three configuration bytes to the data port. The three bytes set the vector base, the cascade word and the mode byte. After that, the data port reads and writes the 8-bit mask. The command port accepts read-select words and specific end-of-interrupt words.

Each input has a request bit, an in-service bit and a mask bit. Priority is fixed, and input 0 is the most urgent. The interrupt line rises when an unmasked request outranks everything in service. The processor answers with two acknowledge pulses. The first pulse moves the winning request into service. The second pulse presents the vector, which is the base plus the input number. In the automatic mode, the second pulse also ends the service, so no end-of-interrupt command is needed. The stored cascade word is passed out unchanged for the system glue. Driving a physical cascade bus is not part of the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the controller is in this state:
  - int_out and vec_valid are 0 and vec_out is 0x00.
  - The mask, request and in-service registers are all zero.
  - A command-port read returns the request register.
  - The controller is unconfigured.
- R2: A command-port write with bit 4 set starts configuration. The next three data-port writes are stored in order as:
  - the vector base;
  - the cascade word, which appears on cascade_cfg;
  - the mode byte.

  Until the third write lands, int_out stays 0 and acknowledge pulses have no effect.
- R3: Outside configuration, a data-port write loads the mask and a data-port read returns it. A start word clears the mask. A mask of 0xFF keeps int_out at 0 whatever the inputs do.
- R4: After a command-port write of 0x0A, command-port reads return the request register. After 0x0B, they return the in-service register. The choice stays in effect across other writes until it is changed.
- R5: The request bit of an input is set by a low-to-high transition on that input. It is cleared when the input is low or when the request moves into service. An input held high after its service does not request again.
- R6: int_out is 1 exactly when an unmasked request has a lower input number than every in-service bit. Input 0 is the highest priority.
- R7: The first acknowledge pulse moves the winning request into service. The second pulse sets vec_out to base + n and holds vec_valid at 1 for one cycle.
- R8: If no request qualifies at the first pulse, the acknowledge still completes. It returns base + 7 and sets no in-service bit.
- R9: A command-port write of 0x60 + n clears in-service bit n and no other bit.
- R10: When bit 1 of the mode byte is set, the second acknowledge pulse clears the in-service bit it reported.
- R11: A specific end-of-interrupt and a first acknowledge pulse in the same cycle both take effect. If they name the same bit, the setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, sampled on the clock edge |
| addr0 | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data (combinational from addr0) |
| irq_in | input | 8 | Interrupt inputs, edge-triggered |
| ack_in | input | 1 | Acknowledge pulse, one cycle per pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector from the last completed acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The in-service register has two writers:
- a command-port end-of-interrupt, which clears one bit;
- the first acknowledge pulse, which sets the winner's bit.

These two can land on the same clock edge. The bench provokes the collision by leaving input 2 in service and then raising input 1. It then drives the 0x62 command and the first acknowledge pulse in the same cycle. It judges the outcome by the in-service register reading 0x02 and by the next vector being base + 1. A second collision is also covered: a request rising while a higher input is in service must stay latched, and it is delivered once that service ends.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_NUM_IN = 8;
  localparam int PIC_DATA_W = 8;
  localparam int PIC_IDX_W  = $clog2(PIC_NUM_IN);

  typedef enum logic [2:0] {
    CFG_BLANK = 3'd0,
    CFG_BASE  = 3'd1,
    CFG_CASC  = 3'd2,
    CFG_MODE  = 3'd3,
    CFG_RUN   = 3'd4
  } cfg_state_t;

  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [4:0] CMD_EOI_TOP = 5'b01100;
endpackage

// File: rtl/pic_cfg_fsm.sv
module pic_cfg_fsm
  import pic_pkg::*;
#(
  parameter int DATA_W = PIC_DATA_W,
  parameter int NUM_IN = PIC_NUM_IN,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              start_pulse,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] casc,
  output logic              auto_eoi,
  output logic [NUM_IN-1:0] mask,
  output logic              sel_svc,
  output logic              eoi_valid,
  output logic [IDX_W-1:0]  eoi_idx
);
  cfg_state_t        st_q, st_d;
  logic [DATA_W-1:0] base_q, base_d, casc_q, casc_d;
  logic              aeoi_q, aeoi_d, sel_q, sel_d;
  logic [NUM_IN-1:0] mask_q, mask_d;
  logic              cmd_wr, dat_wr;

  assign cmd_wr      = wr_en && !addr0;
  assign dat_wr      = wr_en && addr0;
  assign start_pulse = cmd_wr && wdata[4];
  assign eoi_valid   = cmd_wr && !wdata[4] && (st_q == CFG_RUN) &&
                       (wdata[7:3] == CMD_EOI_TOP);
  assign eoi_idx     = wdata[IDX_W-1:0];

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    casc_d = casc_q;
    aeoi_d = aeoi_q;
    sel_d  = sel_q;
    mask_d = mask_q;
    if (start_pulse) begin
      st_d   = CFG_BASE;
      mask_d = '0;
      sel_d  = 1'b0;
    end else if (dat_wr) begin
      unique case (st_q)
        CFG_BASE: begin base_d = wdata; st_d = CFG_CASC; end
        CFG_CASC: begin casc_d = wdata; st_d = CFG_MODE; end
        CFG_MODE: begin aeoi_d = wdata[1]; st_d = CFG_RUN; end
        default:  mask_d = wdata[NUM_IN-1:0];
      endcase
    end else if (cmd_wr && st_q == CFG_RUN) begin
      if (wdata == CMD_SEL_REQ) sel_d = 1'b0;
      else if (wdata == CMD_SEL_SVC) sel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CFG_BLANK;
      base_q <= '0;
      casc_q <= '0;
      aeoi_q <= 1'b0;
      sel_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      casc_q <= casc_d;
      aeoi_q <= aeoi_d;
      sel_q  <= sel_d;
      mask_q <= mask_d;
    end
  end

  assign ready    = (st_q == CFG_RUN);
  assign base     = base_q;
  assign casc     = casc_q;
  assign auto_eoi = aeoi_q;
  assign mask     = mask_q;
  assign sel_svc  = sel_q;
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
#(
  parameter int NUM_IN = PIC_NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] take,
  output logic [NUM_IN-1:0] irr
);
  logic [NUM_IN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_bit
    logic req_q, req_d;
    always_comb begin
      req_d = req_q;
      if (irq_in[g] && !prev_q[g]) req_d = 1'b1;
      if (!irq_in[g] || take[g])   req_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_d;
    end
    assign irr[g] = req_q;
  end
endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res
  import pic_pkg::*;
#(
  parameter int NUM_IN = PIC_NUM_IN,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic [NUM_IN-1:0] irr,
  input  logic [NUM_IN-1:0] mask,
  input  logic [NUM_IN-1:0] isr,
  output logic              win,
  output logic [IDX_W-1:0]  win_idx
);
  logic [NUM_IN-1:0] cand;
  logic              req_any, svc_any;
  logic [IDX_W-1:0]  req_idx, svc_idx;

  assign cand = irr & ~mask;

  always_comb begin
    req_any = 1'b0;
    req_idx = '0;
    svc_any = 1'b0;
    svc_idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        req_any = 1'b1;
        req_idx = IDX_W'(i);
      end
      if (isr[i]) begin
        svc_any = 1'b1;
        svc_idx = IDX_W'(i);
      end
    end
  end

  assign win     = req_any && (!svc_any || (req_idx < svc_idx));
  assign win_idx = req_idx;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int DATA_W = PIC_DATA_W,
  parameter int NUM_IN = PIC_NUM_IN,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              ack_in,
  output logic              int_out,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid,
  output logic [DATA_W-1:0] cascade_cfg
);
  logic              ready, start_pulse, auto_eoi, sel_svc, eoi_valid;
  logic [DATA_W-1:0] base, casc;
  logic [NUM_IN-1:0] mask, irr, take;
  logic [IDX_W-1:0]  eoi_idx, win_idx;
  logic              win;

  logic [NUM_IN-1:0] isr_q, isr_d, isr_set, isr_clr;
  logic              phase_q, phase_d;
  logic [IDX_W-1:0]  held_idx_q, held_idx_d;
  logic              held_spur_q, held_spur_d;
  logic [DATA_W-1:0] vec_q, vec_d;
  logic              vld_q, vld_d;
  logic              ack_fire, ack_first, ack_second;

  pic_cfg_fsm #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(addr0), .wdata(wdata),
    .ready(ready), .start_pulse(start_pulse), .base(base), .casc(casc),
    .auto_eoi(auto_eoi), .mask(mask), .sel_svc(sel_svc),
    .eoi_valid(eoi_valid), .eoi_idx(eoi_idx)
  );

  pic_req_latch #(.NUM_IN(NUM_IN)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .take(take), .irr(irr)
  );

  pic_prio_res #(.NUM_IN(NUM_IN)) u_prio (
    .irr(irr), .mask(mask), .isr(isr_q), .win(win), .win_idx(win_idx)
  );

  assign ack_fire   = ack_in && ready;
  assign ack_first  = ack_fire && !phase_q;
  assign ack_second = ack_fire && phase_q;

  always_comb begin
    isr_set     = '0;
    isr_clr     = '0;
    take        = '0;
    phase_d     = phase_q;
    held_idx_d  = held_idx_q;
    held_spur_d = held_spur_q;
    vec_d       = vec_q;
    vld_d       = 1'b0;
    if (eoi_valid) isr_clr = NUM_IN'(1) << eoi_idx;
    if (ack_first) begin
      phase_d = 1'b1;
      if (win) begin
        held_idx_d  = win_idx;
        held_spur_d = 1'b0;
        isr_set     = NUM_IN'(1) << win_idx;
        take        = NUM_IN'(1) << win_idx;
      end else begin
        held_idx_d  = '1;
        held_spur_d = 1'b1;
      end
    end
    if (ack_second) begin
      phase_d = 1'b0;
      vec_d   = base + DATA_W'(held_idx_q);
      vld_d   = 1'b1;
      if (auto_eoi && !held_spur_q) isr_clr = isr_clr | (NUM_IN'(1) << held_idx_q);
    end
    isr_d = (isr_q & ~isr_clr) | isr_set;
    if (start_pulse) begin
      isr_d   = '0;
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q       <= '0;
      phase_q     <= 1'b0;
      held_idx_q  <= '1;
      held_spur_q <= 1'b0;
      vec_q       <= '0;
      vld_q       <= 1'b0;
    end else begin
      isr_q       <= isr_d;
      phase_q     <= phase_d;
      held_idx_q  <= held_idx_d;
      held_spur_q <= held_spur_d;
      vec_q       <= vec_d;
      vld_q       <= vld_d;
    end
  end

  assign int_out     = ready && win;
  assign vec_out     = vec_q;
  assign vec_valid   = vld_q;
  assign cascade_cfg = casc;
  assign rdata       = addr0 ? DATA_W'(mask) : (sel_svc ? DATA_W'(isr_q) : DATA_W'(irr));
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_IN = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_in,
  input logic              int_out,
  input logic              vec_valid,
  input logic [DATA_W-1:0] vec_out,
  input logic              ready,
  input logic [NUM_IN-1:0] mask,
  input logic [NUM_IN-1:0] irr,
  input logic [NUM_IN-1:0] isr,
  input logic              eoi_valid,
  input logic [IDX_W-1:0]  eoi_idx,
  input logic              held_spur,
  input logic [DATA_W-1:0] base
);
  p_quiet_unready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  p_mask_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !int_out);

  p_int_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (|(irr & ~mask)));

  p_vec_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_spur_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && held_spur) |-> (vec_out == base + DATA_W'(NUM_IN - 1)));

  p_eoi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_in) |=> !isr[$past(eoi_idx)]);
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .int_out(int_out),
  .vec_valid(vec_valid), .vec_out(vec_out), .ready(ready), .mask(mask),
  .irr(irr), .isr(isr_q), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
  .held_spur(held_spur_q), .base(base)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, addr0 = 1'b0, ack_in = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vec_out, cascade_cfg;
  logic       int_out, vec_valid;
  int         checks = 0, fails = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(addr0), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .ack_in(ack_in), .int_out(int_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .cascade_cfg(cascade_cfg)
  );

  // fields: inputs[31:24] mask[23:16] vector[15:8] in-service[7:0], base 0x20
  localparam logic [31:0] TBL [5] = '{
    32'h01_00_20_01,
    32'h84_00_22_04,
    32'h06_02_22_04,
    32'hF0_30_26_40,
    32'h80_00_27_80
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr0 = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr0 = a; #1; d = rdata;
  endtask

  task automatic drive_irq(input logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ack_pair(output logic [7:0] v, output logic ok);
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk); ack_in = 1'b0;
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk); ack_in = 1'b0; v = vec_out; ok = vec_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, r;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
    chk("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
    chk("R1 vec_out", vec_out, 8'h00);
    rd(1'b0, r); chk("R1 request read", r, 8'h00);
    rd(1'b1, r); chk("R1 mask read", r, 8'h00);

    // R2 no delivery before configuration; R5 edge sets request
    drive_irq(8'h01);
    chk("R2 int_out unconfigured", {7'b0, int_out}, 8'h00);
    rd(1'b0, r); chk("R5 edge sets request", r, 8'h01);
    ack_pair(v, ok);
    chk("R2 ack ignored unconfigured", {7'b0, ok}, 8'h00);
    drive_irq(8'h00);
    rd(1'b0, r); chk("R5 low input clears request", r, 8'h00);

    // R2 configuration sequence
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04);
    chk("R2 int_out mid-configuration", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R2 cascade word", cascade_cfg, 8'h04);

    // table walk: R6 R7 R9 R5
    for (int i = 0; i < 5; i++) begin
      logic [7:0] pat, msk, ev, es, bit_n;
      pat = TBL[i][31:24]; msk = TBL[i][23:16]; ev = TBL[i][15:8]; es = TBL[i][7:0];
      bit_n = ev - 8'h20;
      wr(1'b1, msk);
      drive_irq(pat);
      chk("R6 int_out raised", {7'b0, int_out}, 8'h01);
      ack_pair(v, ok);
      chk("R7 vector", v, ev);
      chk("R7 vec_valid", {7'b0, ok}, 8'h01);
      wr(1'b0, 8'h0B);
      rd(1'b0, r); chk("R7 in-service after ack", r, es);
      wr(1'b0, 8'h60 + bit_n);
      rd(1'b0, r); chk("R9 specific EOI", r, 8'h00);
      chk("R5 no re-request while held high", {7'b0, int_out},
          {7'b0, |(pat & ~msk & ~(8'h01 << bit_n))});
      drive_irq(8'h00);
      wr(1'b0, 8'h0A);
      rd(1'b0, r); chk("R5 requests cleared", r, 8'h00);
      wr(1'b1, 8'h00);
    end

    // R3 mask all
    wr(1'b1, 8'hFF);
    rd(1'b1, r); chk("R3 mask read back", r, 8'hFF);
    drive_irq(8'h3C);
    chk("R3 all masked", {7'b0, int_out}, 8'h00);
    drive_irq(8'h00);
    wr(1'b1, 8'h00);

    // R6 blocking by in-service, R11 same-cycle EOI and first pulse
    drive_irq(8'h04);
    ack_pair(v, ok); chk("R7 vector input 2", v, 8'h22);
    drive_irq(8'h24);
    chk("R6 lower priority blocked", {7'b0, int_out}, 8'h00);
    drive_irq(8'h26);
    chk("R6 higher priority passes", {7'b0, int_out}, 8'h01);
    @(negedge clk); addr0 = 1'b0; wdata = 8'h62; wr_en = 1'b1; ack_in = 1'b1;
    @(negedge clk); wr_en = 1'b0; ack_in = 1'b0;
    @(negedge clk); ack_in = 1'b1;
    @(negedge clk); ack_in = 1'b0;
    chk("R11 vector after collision", vec_out, 8'h21);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R11 in-service after collision", r, 8'h02);
    wr(1'b0, 8'h61);
    chk("R6 pending input 5 delivered", {7'b0, int_out}, 8'h01);
    ack_pair(v, ok); chk("R7 vector input 5", v, 8'h25);
    wr(1'b0, 8'h65);
    rd(1'b0, r); chk("R9 in-service empty", r, 8'h00);
    drive_irq(8'h00);

    // R4 read selection persists
    drive_irq(8'h40);
    rd(1'b0, r); chk("R4 in-service selected", r, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, r); chk("R4 request selected", r, 8'h40);
    wr(1'b1, 8'h00);
    rd(1'b0, r); chk("R4 selection persists", r, 8'h40);
    wr(1'b0, 8'h0B);
    drive_irq(8'h00);

    // R8 spurious
    drive_irq(8'h10);
    drive_irq(8'h00);
    chk("R8 int_out after withdrawal", {7'b0, int_out}, 8'h00);
    ack_pair(v, ok);
    chk("R8 spurious vector", v, 8'h27);
    chk("R8 spurious vec_valid", {7'b0, ok}, 8'h01);
    rd(1'b0, r); chk("R8 no in-service bit", r, 8'h00);

    // R3 start word clears mask, R10 automatic end-of-interrupt
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h11);
    rd(1'b1, r); chk("R3 start clears mask", r, 8'h00);
    wr(1'b1, 8'h40); wr(1'b1, 8'h02); wr(1'b1, 8'h02);
    chk("R2 cascade word reconfigured", cascade_cfg, 8'h02);
    drive_irq(8'h08);
    ack_pair(v, ok);
    chk("R10 vector", v, 8'h43);
    wr(1'b0, 8'h0B);
    rd(1'b0, r); chk("R10 auto cleared", r, 8'h00);
    chk("R10 int_out idle", {7'b0, int_out}, 8'h00);
    drive_irq(8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule